// File: doc/BRIEF.md
# Converter Restart and Frame Sequencer

This block paces the output side of a continuously running oversampled converter from its master clock. After the active-low reset is released, it holds a calibration-busy flag for a long calibration and filter-settling interval. It then emits a one-cycle frame strobe at a fixed divided rate. On every strobe it registers the incoming conversion word, so downstream logic always sees a word that stays stable for a whole frame.

A rising edge on the synchronization input restarts the output phase without recalibrating. The settled flag drops and a shorter settling interval runs. After that, frames resume on a grid anchored to the clock edge that recognized the sync. Several converters fed the same sync edge therefore produce frames on the same clock cycles. A sync edge seen while calibration is still running has no effect.

The reset input is sampled synchronously. The settling lengths and the frame period are parameters, with defaults of 988205, 5161 and 64 cycles.

Top module: `conv_seq_ctrl`

## Requirements
- R1: While rst_n is sampled low, cal_busy is 1, settled is 0, frame_strobe is 0 and word_q is 0.
- R2: Number the rising clock edges from 1, starting with the first edge at which rst_n is sampled high. frame_strobe first goes high after edge CAL_LEN, and cal_busy falls at that same edge.
- R3: In steady running, frame_strobe is high for exactly one cycle, every PERIOD edges after the previous strobe.
- R4: Sync is recognized at an edge that samples sync_in high when the previous edge sampled it low. If the recognition edge is S, frame_strobe is high after edges S+SYNC_LEN+n*PERIOD for n ≥ 0, and no strobe occurs between S and S+SYNC_LEN.
- R5: Holding sync_in high produces only one recognition. No further restart happens until sync_in has been sampled low and then high again.
- R6: A sync recognized while a previous sync is still settling restarts the SYNC_LEN count from the new recognition edge.
- R7: A sync edge seen at any edge up to and including edge CAL_LEN after reset release is ignored, and strobe timing follows R2 and R3.
- R8: At each edge that raises frame_strobe, word_q takes the value data_in had at that edge. word_q holds its value at all other edges.
- R9: If a sync is recognized at an edge where a frame strobe was due, the strobe is suppressed and the sync timing of R4 applies.
- R10: settled goes low at a sync recognition edge. settled goes high together with the first frame_strobe after reset or after a sync, and stays high until the next reset or recognized sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Frame realignment request, acts on its rising edge |
| data_in | input | DATA_W | Conversion word from the filter |
| cal_busy | output | 1 | High from reset until calibration settling ends |
| settled | output | 1 | High while output words are fully settled |
| frame_strobe | output | 1 | One-cycle pulse marking each output word |
| word_q | output | DATA_W | Conversion word captured on the last strobe |

## Verification
A wrong count in the settle timer moves the first strobe after reset or sync. The bench therefore sees the error at the first strobe, no more than CAL_LEN or SYNC_LEN cycles after the restart. A wrong phase counter shows as a strobe one or more cycles off the expected grid within one frame period. A broken edge detector shows as a second settling gap while sync is held high, or as a sync that fails to drop settled at once. The bench sweeps the sync edge across every phase of the frame. It also covers the boundaries: a sync on the last calibration edge, a sync on a strobe edge, and a sync that restarts an ongoing settle.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_CAL    = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);

  logic level_d;

  // the previous sample keeps tracking during reset, so a level that is
  // already high at release does not count as an edge
  always_ff @(posedge clk) begin
    level_d <= level_in;
  end

  assign rise = level_in & ~level_d;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R5

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == last);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last)); // R2

endmodule

// File: rtl/frame_divider.sv
module frame_divider #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);

  localparam int PH_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase <= '0;
    end else if (run) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  assign tick = run && (phase == PH_LAST);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_LAST); // R3

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CAL_LEN  = 988205,
  parameter int SYNC_LEN = 5161,
  parameter int PERIOD   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              cal_busy,
  output logic              settled,
  output logic              frame_strobe,
  output logic [DATA_W-1:0] word_q
);

  localparam int MAX_LEN = max_of(CAL_LEN, SYNC_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_LEN - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_LEN - 1);

  seq_state_t       state;
  logic             sync_rise;
  logic             resync;
  logic             t_done;
  logic             t_clear;
  logic             t_run;
  logic [CNT_W-1:0] t_last;
  logic             d_tick;
  logic             d_run;
  logic             d_clear;
  logic             take;

  sync_rise_det u_rise (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (sync_in),
    .rise     (sync_rise)
  );

  settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (t_clear),
    .run   (t_run),
    .last  (t_last),
    .done  (t_done)
  );

  frame_divider #(.PERIOD(PERIOD)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (d_clear),
    .run   (d_run),
    .tick  (d_tick)
  );

  always_comb begin
    resync  = sync_rise && (state != SEQ_CAL);
    t_run   = (state != SEQ_RUN);
    t_last  = (state == SEQ_CAL) ? CAL_LAST : SYNC_LAST;
    t_clear = resync || t_done;
    d_run   = (state == SEQ_RUN) && !resync;
    d_clear = resync || t_done;
    take    = !resync && (t_done || d_tick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SEQ_CAL;
      cal_busy     <= 1'b1;
      settled      <= 1'b0;
      frame_strobe <= 1'b0;
      word_q       <= '0;
    end else begin
      frame_strobe <= take;
      if (take) begin
        word_q <= data_in;
      end
      if (resync) begin
        state   <= SEQ_SETTLE;
        settled <= 1'b0;
      end else if (t_done) begin
        state    <= SEQ_RUN;
        settled  <= 1'b1;
        cal_busy <= 1'b0;
      end
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe); // R3
  AST_NO_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !frame_strobe); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |-> $stable(word_q)); // R8
  AST_SETTLE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> frame_strobe); // R10
  AST_RESYNC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!settled && !frame_strobe)); // R4
  AST_CAL_IGNORES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_CAL) |=> (state != SEQ_SETTLE)); // R7

endmodule

// File: tb/conv_seq_ctrl_bench.sv
module conv_seq_ctrl_bench;

  localparam int DATA_W   = 16;
  localparam int CAL_LEN  = 40;
  localparam int SYNC_LEN = 13;
  localparam int PERIOD   = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sync_in;
  logic [DATA_W-1:0] data_in;
  logic              cal_busy;
  logic              settled;
  logic              frame_strobe;
  logic [DATA_W-1:0] word_q;

  always #5 clk = ~clk;

  conv_seq_ctrl #(
    .DATA_W(DATA_W), .CAL_LEN(CAL_LEN), .SYNC_LEN(SYNC_LEN), .PERIOD(PERIOD)
  ) u_conv_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .data_in(data_in),
    .cal_busy(cal_busy), .settled(settled), .frame_strobe(frame_strobe),
    .word_q(word_q)
  );

  int tests = 0;
  int fails = 0;
  int k, anchor, len;
  logic prev_s;
  logic [DATA_W-1:0] exp_word;

  function automatic logic [DATA_W-1:0] fval(input int n);
    return DATA_W'(n * 613 + 4660);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, what, k, act, exp);
    end
  endtask

  // drive at a falling edge, model the next rising edge, check at the next falling edge
  task automatic step(input logic s, input string tag);
    logic es, ese;
    sync_in = s;
    data_in = fval(k + 1);
    @(posedge clk);
    k++;
    if (sync_in && !prev_s && k > CAL_LEN) begin
      anchor = k;
      len = SYNC_LEN;
    end
    prev_s = sync_in;
    ese = (k >= anchor + len);
    es  = ese && (((k - anchor - len) % PERIOD) == 0);
    if (es) exp_word = fval(k);
    @(negedge clk);
    check(tag, "strobe", 32'(frame_strobe), 32'(es));
    check("R10", "settled", 32'(settled), 32'(ese));
    check("R2", "cal_busy", 32'(cal_busy), 32'(k < CAL_LEN));
    check("R8", "word_q", 32'(word_q), 32'(exp_word));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic reset_phase(input int n);
    rst_n = 1'b0;
    sync_in = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    check("R1", "cal_busy", 32'(cal_busy), 32'd1);
    check("R1", "settled", 32'(settled), 32'd0);
    check("R1", "strobe", 32'(frame_strobe), 32'd0);
    check("R1", "word_q", 32'(word_q), 32'd0);
    rst_n = 1'b1;
    k = 0;
    anchor = 0;
    len = CAL_LEN;
    prev_s = 1'b0;
    exp_word = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sync_in = 1'b0;
    data_in = '0;
    @(negedge clk);
    reset_phase(3);
    run(CAL_LEN + 4 * PERIOD, "R3");

    // held sync: one restart only
    for (int i = 0; i < 3 * SYNC_LEN; i++) step(1'b1, "R5");
    run(2 * PERIOD, "R5");

    // restart during settling
    step(1'b1, "R6");
    run(5, "R6");
    step(1'b1, "R6");
    run(SYNC_LEN + 2 * PERIOD, "R6");

    // sync landing on a due strobe edge
    while (!((k + 1 >= anchor + len) && (((k + 1 - anchor - len) % PERIOD) == 0)))
      step(1'b0, "R9");
    step(1'b1, "R9");
    run(SYNC_LEN + 2 * PERIOD, "R9");

    // sync at every frame phase
    for (int p = 0; p < PERIOD; p++) begin
      run(p, "R4");
      step(1'b1, "R4");
      run(SYNC_LEN + 2 * PERIOD, "R4");
    end

    // mid-run reset, then syncs during calibration including its last edge
    reset_phase(2);
    run(10, "R7");
    step(1'b1, "R7");
    run(CAL_LEN - 1 - k, "R7");
    step(1'b1, "R7");
    step(1'b1, "R7");
    step(1'b1, "R7");
    run(3 * PERIOD, "R7");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule